// File: doc/BRIEF.md
# Parallel Printer Strobe Controller

This block sits between a simple synchronous register port and a parallel printer interface. Software writes a byte into a data register, and the block presents that byte on a latched output. It then produces the printer strobe in one of two ways. In auto mode the strobe is timed by hardware. In manual mode software sets the strobe level through a control bit. A second control bit drives the printer initialise (prime) line directly.

In auto mode, a data write starts a two-phase sequence. First there is a quiet wait. Then the strobe is held active for the same length of time. Each phase lasts 2 µs or 8 µs, as selected by a control bit. The interval is converted to clock cycles from the `CLK_MHZ` parameter. A status bit reports that a sequence is running. The register port takes a write in every cycle and has no back-pressure, so software should poll the busy flag before it writes the next byte. A write made while busy is still accepted, and it restarts the sequence with the new byte.

Top module: `printer_strobe_ctl`

## Requirements
- R1: After reset the control bits, `data_o`, `strobe_o`, `prime_o` and the busy flag are all 0. The block therefore starts in auto mode with the short interval.
- R2: In auto mode (control bit 0 = 0), a write to address 0 with control bit 1 = 0 keeps `strobe_o` low for N = 2*CLK_MHZ cycles after the write edge. It then holds `strobe_o` high for N cycles, and after that returns it to low.
- R3: With control bit 1 = 1 the same sequence uses N = 8*CLK_MHZ cycles for each phase. The interval is captured at the data write.
- R4: `data_o` loads the written byte on every write to address 0, in either mode, and holds it until the next such write.
- R5: Reading address 2 returns the busy flag in bit 0, with all other bits 0. The flag is 1 from the data write edge until the strobe phase ends.
- R6: A data write in auto mode while busy loads the new byte and restarts the sequence from the start of the wait phase.
- R7: In manual mode (control bit 0 = 1), data writes never start a sequence, and `strobe_o` equals control bit 2.
- R8: A control write that sets manual mode aborts any running sequence in the same edge. Busy reads 0 and `strobe_o` follows control bit 2 from the next cycle.
- R9: `prime_o` equals control bit 3 in both modes.
- R10: Reading address 1 returns the control bits in [3:0] with zeros above them. Reading address 0 returns the data byte. `rdata` is combinational from `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| data_o | output | 8 | Latched printer data byte |
| strobe_o | output | 1 | Printer strobe, active high |
| prime_o | output | 1 | Printer initialise line, active high |

## Verification
Auto-mode sequences are driven with both interval settings and with random bytes. The strobe is sampled in every cycle of the wait and drive phases, which separates an off-by-one in either phase from a wrong interval choice. Manual mode is driven with random strobe and prime bits, and a data write is included to show that no sequence starts. Two directed cases cover the interactions that random traffic rarely reaches: a second data write landing in the drive phase, which must restart the sequence, and a switch to manual mode in the middle of a drive, which must abort it.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_DRIVE = 2'd2
  } phase_t;
endpackage

// File: rtl/psc_regs.sv
module psc_regs
  import psc_pkg::*;
#(
  parameter int DW = 8,
  parameter int CTW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  data_q,
  output logic [CTW-1:0] ctl_q,
  output logic           data_wr,
  output logic           ctl_wr
);
  assign data_wr = wr_en && (addr == ADDR_DATA);
  assign ctl_wr  = wr_en && (addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (data_wr) data_q <= wdata;
      if (ctl_wr)  ctl_q  <= wdata[CTW-1:0];
    end
  end
endmodule

// File: rtl/psc_seq.sv
module psc_seq
  import psc_pkg::*;
#(
  parameter int SHORT_CYC = 100,
  parameter int LONG_CYC = 400,
  localparam int CW = $clog2(LONG_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  input  logic abort,
  output logic busy,
  output logic drive
);
  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          len_long;
  logic [CW-1:0] reload;

  assign reload = len_long ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      len_long <= 1'b0;
    end else if (abort) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (start) begin
      phase    <= PH_WAIT;
      len_long <= long_sel;
      cnt      <= long_sel ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
    end else begin
      unique case (phase)
        PH_WAIT: begin
          if (cnt == '0) begin
            phase <= PH_DRIVE;
            cnt   <= reload;
          end else cnt <= cnt - 1'b1;
        end
        PH_DRIVE: begin
          if (cnt == '0) phase <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign busy  = (phase != PH_IDLE);
  assign drive = (phase == PH_DRIVE);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LONG_CYC - 1));

  // R2
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (cnt == '0 || $past(phase) == PH_DRIVE));
endmodule

// File: rtl/printer_strobe_ctl.sv
module printer_strobe_ctl
  import psc_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int DW = 8,
  localparam int SHORT_CYC = 2 * CLK_MHZ,
  localparam int LONG_CYC = 8 * CLK_MHZ,
  localparam int CTW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] data_o,
  output logic          strobe_o,
  output logic          prime_o
);
  logic [CTW-1:0] ctl_q;
  logic           data_wr, ctl_wr;
  logic           busy, drive;
  logic           manual, abort, start;

  psc_regs #(.DW(DW), .CTW(CTW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .data_q(data_o), .ctl_q(ctl_q), .data_wr(data_wr), .ctl_wr(ctl_wr)
  );

  assign manual = ctl_q[0];
  assign abort  = manual || (ctl_wr && wdata[0]);
  assign start  = data_wr && !manual;

  psc_seq #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .long_sel(ctl_q[1]),
    .abort(abort), .busy(busy), .drive(drive)
  );

  assign strobe_o = manual ? ctl_q[2] : drive;
  assign prime_o  = ctl_q[3];

  always_comb begin
    unique case (addr)
      ADDR_DATA: rdata = data_o;
      ADDR_CTRL: rdata = DW'(ctl_q);
      ADDR_STAT: rdata = DW'(busy);
      default:   rdata = '0;
    endcase
  end

  // R8
  manual_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    manual |-> !busy);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(data_o));

  // R6
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(data_wr));

  // R7
  manual_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && data_wr) |=> !busy);
endmodule

// File: tb/printer_strobe_ctl_test.sv
module printer_strobe_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 4;
  localparam int NS = 2 * MHZ;
  localparam int NL = 8 * MHZ;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, data_o;
  logic strobe_o, prime_o;
  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  printer_strobe_ctl #(.CLK_MHZ(MHZ)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .data_o(data_o), .strobe_o(strobe_o), .prime_o(prime_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_strobe(int i, int n);
    return (i >= n) && (i < 2 * n);
  endfunction

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 0; addr = 2'd2;
  endtask

  task automatic run_auto(string req, logic [7:0] d, bit lng);
    int n = lng ? NL : NS;
    wr(2'd0, d);
    for (int i = 0; i <= 2 * n; i++) begin
      @(negedge clk);
      check(req, strobe_o, exp_strobe(i, n));
      check("R5", rdata, (i < 2 * n) ? 8'd1 : 8'd0);
      check("R4", data_o, d);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {data_o, strobe_o, prime_o}, 0);
    addr = 2'd1; #1 check("R1", rdata, 0);
    addr = 2'd2; #1 check("R1", rdata, 0);
    rst_n = 1;

    run_auto("R2", 8'hA5, 0);
    wr(2'd1, 8'h02);
    run_auto("R3", 8'h3C, 1);
    wr(2'd1, 8'h00);

    // R6 restart during drive phase
    wr(2'd0, 8'h11);
    repeat (NS + 2) @(negedge clk);
    check("R6", strobe_o, 1);
    run_auto("R6", 8'h22, 0);

    // R8 abort mid-drive
    wr(2'd0, 8'h33);
    repeat (NS + 1) @(negedge clk);
    check("R8", strobe_o, 1);
    wr(2'd1, 8'h01);
    @(negedge clk);
    check("R8", strobe_o, 0);
    check("R8", rdata, 0);

    // R10 readback
    wr(2'd1, 8'hFD);
    addr = 2'd1; #1 check("R10", rdata, 8'h0D);
    addr = 2'd0; #1 check("R10", rdata, 8'h33);

    // random mix
    process::self().srandom(32'd1234);
    for (int k = 0; k < 24; k++) begin
      logic [3:0] c = 4'($urandom);
      logic [7:0] d = 8'($urandom);
      wr(2'd1, {4'h0, c});
      @(negedge clk);
      check("R9", prime_o, c[3]);
      if (c[0]) begin
        check("R7", strobe_o, c[2]);
        wr(2'd0, d);
        repeat (3) begin
          @(negedge clk);
          check("R7", strobe_o, c[2]);
          check("R7", rdata, 0);
        end
        check("R4", data_o, d);
      end else begin
        run_auto(c[1] ? "R3" : "R2", d, c[1]);
        check("R9", prime_o, c[3]);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule